// File: doc/BRIEF.md
# Local-Store Transfer Command Queue

This block executes software-issued transfer commands that copy data between a processing element's private local store and main memory. Software places a command on the enqueue port with a local-store address, a main-memory address, a byte length, a direction and a 5-bit tag. The block answers in the same cycle with accepted, queue-full or malformed. Accepted commands wait in a sixteen-entry first-in first-out queue. A command's entry stays occupied until its last beat finishes, so sixteen commands can be outstanding, counting the one being executed.

Commands run one at a time in arrival order. Each one is split into 16-byte beats that are issued in ascending address order. A beat is a read from the source side followed by a write to the destination side. Main memory is reached through a request/response master. The local store is reached through a requester toward its arbiter, and that arbiter gives this requester top priority. Beat-level work is the only scheduling the block does. When a command's last beat completes, the completion bit for its tag is set. Software clears completion bits with a write-one mask.

Top module: `dma_cmd_queue`

## Requirements
- R1: A command presented with `cmd_valid` is accepted (`cmd_ack` high in the same cycle) when it is well formed and fewer than 16 commands are outstanding. A command counts as outstanding from acceptance until its completion bit is set.
- R2: When 16 commands are outstanding, a new command gets `cmd_full` high and `cmd_ack` low, and it is not stored.
- R3: A command is malformed when its length exceeds 16384 bytes, or when its length, local address or main address has any of bits [3:0] set. A malformed command gets `cmd_bad` and is not stored. A length of exactly 16384 bytes is legal. When the queue is full, `cmd_full` takes priority over `cmd_bad`, and at most one of the three responses is high.
- R4: With `cmd_dir` = 0 (get), each beat reads main memory at the current main address and writes that data to the local store at the current local address.
- R5: With `cmd_dir` = 1 (put), each beat reads the local store and writes that data to main memory. Local-store read data is taken one cycle after the grant.
- R6: Beats are 16 bytes. Within a command, addresses rise by 16 per beat, starting at the command's addresses, and a command makes length/16 beats. Commands start in acceptance order.
- R7: When a command's last beat completes, `cmpl_status[tag]` is set. It stays set until software writes a 1 to the same bit of `cmpl_clr`, and other bits are unaffected. A set and a clear of the same bit in the same cycle leaves the bit set.
- R8: A zero-length command sets its completion bit without any main-memory or local-store request.
- R9: `mem_req` is held with a stable address until `mem_rsp`, and `ls_req` is held with a stable address until `ls_gnt`. `mem_req` and `ls_req` are never high together. `mem_we` = 1 marks a write, `ls_we` = 1 marks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command presented |
| cmd_laddr | input | LA_W | Local-store byte address |
| cmd_maddr | input | MA_W | Main-memory byte address |
| cmd_len | input | LEN_W | Length in bytes |
| cmd_dir | input | 1 | 0 = main to local, 1 = local to main |
| cmd_tag | input | TAG_W | Completion tag |
| cmd_ack | output | 1 | Command accepted |
| cmd_full | output | 1 | Refused, queue full |
| cmd_bad | output | 1 | Refused, malformed |
| ls_req | output | 1 | Local-store access request |
| ls_we | output | 1 | Local-store write |
| ls_addr | output | LA_W | Local-store address |
| ls_wdata | output | DATA_W | Local-store write data |
| ls_gnt | input | 1 | Local-store grant |
| ls_rdata | input | DATA_W | Local-store read data, cycle after grant |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write |
| mem_addr | output | MA_W | Main-memory address |
| mem_wdata | output | DATA_W | Main-memory write data |
| mem_rsp | input | 1 | Main-memory response, one-cycle pulse |
| mem_rdata | input | DATA_W | Main-memory read data, valid with response |
| cmpl_status | output | 2**TAG_W | Per-tag completion bits |
| cmpl_clr | input | 2**TAG_W | Write-one-to-clear mask |

## Verification
Directed single commands in each direction establish that data lands at the right words, and the recorded address trail shows whether beats rise by 16 from the command's base. Stalling both responders while sixteen one-beat commands queue up separates the real depth limit from an off-by-one, and the order of the first served addresses after release shows whether commands start in arrival order. Zero-length, 16384-byte, 16400-byte and misaligned commands probe the boundaries of the size and alignment checks. Random batches of mixed-direction, overlapping commands, served with random response delays, are compared against a sequential model and expose any beat that is reordered, dropped or has its data latched in the wrong cycle.

// File: rtl/dma_cq_pkg.sv
package dma_cq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRC,
    ST_LSD,
    ST_DST
  } eng_state_e;
endpackage

// File: rtl/dma_cq_fifo.sv
module dma_cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/dma_cq_beat_engine.sv
module dma_cq_beat_engine
  import dma_cq_pkg::*;
#(
  parameter int LA_W   = 18,
  parameter int MA_W   = 32,
  parameter int LEN_W  = 15,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_empty,
  input  logic [LA_W-1:0]   head_laddr,
  input  logic [MA_W-1:0]   head_maddr,
  input  logic [LEN_W-1:0]  head_len,
  input  logic              head_dir,
  input  logic [TAG_W-1:0]  head_tag,
  output logic              pop,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag,
  output logic              ls_req,
  output logic              ls_we,
  output logic [LA_W-1:0]   ls_addr,
  output logic [DATA_W-1:0] ls_wdata,
  input  logic              ls_gnt,
  input  logic [DATA_W-1:0] ls_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int OFS        = $clog2(BEAT_BYTES);
  localparam int BW         = LEN_W - OFS;

  eng_state_e        st_q, st_d;
  logic [LA_W-1:0]   la_q, la_d;
  logic [MA_W-1:0]   ma_q, ma_d;
  logic [BW-1:0]     beats_q, beats_d;
  logic              dir_q, dir_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              dst_ok;

  assign dst_ok = dir_q ? mem_rsp : ls_gnt;

  always_comb begin
    st_d     = st_q;
    la_d     = la_q;
    ma_d     = ma_q;
    beats_d  = beats_q;
    dir_d    = dir_q;
    tag_d    = tag_q;
    buf_d    = buf_q;
    pop      = 1'b0;
    done     = 1'b0;
    done_tag = tag_q;
    unique case (st_q)
      ST_IDLE: if (!head_empty) begin
        if (head_len == '0) begin
          pop      = 1'b1;
          done     = 1'b1;
          done_tag = head_tag;
        end else begin
          la_d    = head_laddr;
          ma_d    = head_maddr;
          beats_d = head_len[LEN_W-1:OFS];
          dir_d   = head_dir;
          tag_d   = head_tag;
          st_d    = ST_SRC;
        end
      end
      ST_SRC: begin
        if (!dir_q && mem_rsp) begin
          buf_d = mem_rdata;
          st_d  = ST_DST;
        end else if (dir_q && ls_gnt) begin
          st_d = ST_LSD;
        end
      end
      ST_LSD: begin
        buf_d = ls_rdata;
        st_d  = ST_DST;
      end
      ST_DST: if (dst_ok) begin
        if (beats_q == BW'(1)) begin
          pop  = 1'b1;
          done = 1'b1;
          st_d = ST_IDLE;
        end else begin
          la_d    = la_q + LA_W'(BEAT_BYTES);
          ma_d    = ma_q + MA_W'(BEAT_BYTES);
          beats_d = beats_q - 1'b1;
          st_d    = ST_SRC;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      la_q    <= '0;
      ma_q    <= '0;
      beats_q <= '0;
      dir_q   <= 1'b0;
      tag_q   <= '0;
      buf_q   <= '0;
    end else begin
      st_q    <= st_d;
      la_q    <= la_d;
      ma_q    <= ma_d;
      beats_q <= beats_d;
      dir_q   <= dir_d;
      tag_q   <= tag_d;
      buf_q   <= buf_d;
    end
  end

  assign mem_req   = ((st_q == ST_SRC) && !dir_q) || ((st_q == ST_DST) && dir_q);
  assign mem_we    = dir_q;
  assign mem_addr  = ma_q;
  assign mem_wdata = buf_q;
  assign ls_req    = ((st_q == ST_SRC) && dir_q) || ((st_q == ST_DST) && !dir_q);
  assign ls_we     = !dir_q;
  assign ls_addr   = la_q;
  assign ls_wdata  = buf_q;
endmodule

// File: rtl/dma_cq_tag_status.sv
module dma_cq_tag_status #(
  parameter int TAG_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [TAG_W-1:0]    set_tag,
  input  logic [2**TAG_W-1:0] clr_mask,
  output logic [2**TAG_W-1:0] status
);
  localparam int NT = 2**TAG_W;

  logic [NT-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q & ~clr_mask;
    if (set_en) st_d[set_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;
endmodule

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue #(
  parameter int DEPTH     = 16,
  parameter int LA_W      = 18,
  parameter int MA_W      = 32,
  parameter int MAX_BYTES = 16384,
  parameter int TAG_W     = 5,
  parameter int DATA_W    = 128,
  parameter int LEN_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [LA_W-1:0]     cmd_laddr,
  input  logic [MA_W-1:0]     cmd_maddr,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic                cmd_dir,
  input  logic [TAG_W-1:0]    cmd_tag,
  output logic                cmd_ack,
  output logic                cmd_full,
  output logic                cmd_bad,
  output logic                ls_req,
  output logic                ls_we,
  output logic [LA_W-1:0]     ls_addr,
  output logic [DATA_W-1:0]   ls_wdata,
  input  logic                ls_gnt,
  input  logic [DATA_W-1:0]   ls_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [MA_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_rsp,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2**TAG_W-1:0] cmpl_status,
  input  logic [2**TAG_W-1:0] cmpl_clr
);
  localparam int OFS = $clog2(DATA_W / 8);
  localparam int EW  = TAG_W + 1 + LEN_W + MA_W + LA_W;

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic          well_formed, q_full, q_empty, q_push, q_pop;
  logic [EW-1:0] q_dout;

  assign well_formed = (cmd_len <= LEN_W'(MAX_BYTES)) &&
                       (cmd_len[OFS-1:0] == '0) &&
                       (cmd_laddr[OFS-1:0] == '0) &&
                       (cmd_maddr[OFS-1:0] == '0);
  assign cmd_full = cmd_valid && q_full;
  assign cmd_bad  = cmd_valid && !q_full && !well_formed;
  assign cmd_ack  = cmd_valid && !q_full && well_formed;
  assign q_push   = cmd_ack;

  dma_cq_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (q_push),
    .pop   (q_pop),
    .din   ({cmd_tag, cmd_dir, cmd_len, cmd_maddr, cmd_laddr}),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  logic             eng_done;
  logic [TAG_W-1:0] eng_tag;

  dma_cq_beat_engine #(
    .LA_W(LA_W), .MA_W(MA_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) eng_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .head_empty (q_empty),
    .head_laddr (q_dout[LA_W-1:0]),
    .head_maddr (q_dout[LA_W +: MA_W]),
    .head_len   (q_dout[LA_W+MA_W +: LEN_W]),
    .head_dir   (q_dout[LA_W+MA_W+LEN_W]),
    .head_tag   (q_dout[EW-1 -: TAG_W]),
    .pop        (q_pop),
    .done       (eng_done),
    .done_tag   (eng_tag),
    .ls_req     (ls_req),
    .ls_we      (ls_we),
    .ls_addr    (ls_addr),
    .ls_wdata   (ls_wdata),
    .ls_gnt     (ls_gnt),
    .ls_rdata   (ls_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rsp    (mem_rsp),
    .mem_rdata  (mem_rdata)
  );

  dma_cq_tag_status #(.TAG_W(TAG_W)) stat_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_en   (eng_done),
    .set_tag  (eng_tag),
    .clr_mask (cmpl_clr),
    .status   (cmpl_status)
  );
endmodule

// File: rtl/dma_cq_checker.sv
module dma_cq_checker #(
  parameter int LA_W      = 18,
  parameter int MA_W      = 32,
  parameter int MAX_BYTES = 16384,
  parameter int LEN_W     = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [LA_W-1:0]  cmd_laddr,
  input logic [MA_W-1:0]  cmd_maddr,
  input logic [LEN_W-1:0] cmd_len,
  input logic             cmd_ack,
  input logic             cmd_full,
  input logic             cmd_bad,
  input logic             mem_req,
  input logic             mem_rsp,
  input logic [MA_W-1:0]  mem_addr,
  input logic             ls_req,
  input logic             ls_gnt,
  input logic [LA_W-1:0]  ls_addr
);
  a_r3_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ack, cmd_full, cmd_bad}));

  a_r3_oversize_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_len > LEN_W'(MAX_BYTES))) |-> !cmd_ack);

  a_r3_misaligned_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ((cmd_len[3:0] != 4'h0) || (cmd_laddr[3:0] != 4'h0) ||
                   (cmd_maddr[3:0] != 4'h0))) |-> !cmd_ack);

  a_r9_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr)));

  a_r9_ls_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && !ls_gnt) |=> (ls_req && $stable(ls_addr)));

  a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && ls_req));

  a_r6_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[3:0] == 4'h0));
endmodule

bind dma_cmd_queue dma_cq_checker #(
  .LA_W(LA_W), .MA_W(MA_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_laddr (cmd_laddr),
  .cmd_maddr (cmd_maddr),
  .cmd_len   (cmd_len),
  .cmd_ack   (cmd_ack),
  .cmd_full  (cmd_full),
  .cmd_bad   (cmd_bad),
  .mem_req   (mem_req),
  .mem_rsp   (mem_rsp),
  .mem_addr  (mem_addr),
  .ls_req    (ls_req),
  .ls_gnt    (ls_gnt),
  .ls_addr   (ls_addr)
);

// File: tb/dma_cmd_queue_tb_top.sv
module dma_cmd_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LA_W = 18, MA_W = 32, LEN_W = 15, TAG_W = 5, DW = 128;
  localparam int NT = 2**TAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic [LA_W-1:0]  cmd_laddr = '0;
  logic [MA_W-1:0]  cmd_maddr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic             cmd_dir = 1'b0;
  logic [TAG_W-1:0] cmd_tag = '0;
  logic             cmd_ack, cmd_full, cmd_bad;
  logic             ls_req, ls_we, mem_req, mem_we;
  logic [LA_W-1:0]  ls_addr;
  logic [MA_W-1:0]  mem_addr;
  logic [DW-1:0]    ls_wdata, mem_wdata;
  logic             ls_gnt = 1'b0, mem_rsp = 1'b0;
  logic [DW-1:0]    ls_rdata = '0, mem_rdata = '0;
  logic [NT-1:0]    cmpl_status;
  logic [NT-1:0]    cmpl_clr = '0;

  dma_cmd_queue dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_laddr(cmd_laddr),
    .cmd_maddr(cmd_maddr), .cmd_len(cmd_len), .cmd_dir(cmd_dir), .cmd_tag(cmd_tag),
    .cmd_ack(cmd_ack), .cmd_full(cmd_full), .cmd_bad(cmd_bad),
    .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .ls_gnt(ls_gnt), .ls_rdata(ls_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp(mem_rsp),
    .mem_rdata(mem_rdata), .cmpl_status(cmpl_status), .cmpl_clr(cmpl_clr)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mem_m [256];
  logic [DW-1:0] ls_m  [256];
  logic [DW-1:0] mem_e [256];
  logic [DW-1:0] ls_e  [256];
  logic [31:0]   addr_log [4096];
  int  mem_served = 0, ls_served = 0;
  bit  hold = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // main-memory and local-store responders with random latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp = 1'b0;
      ls_gnt  = 1'b0;
      if (mem_req && !hold && ($urandom % 3 != 0)) begin
        mem_rsp = 1'b1;
        addr_log[mem_served % 4096] = mem_addr;
        mem_served++;
        if (mem_we) mem_m[mem_addr[11:4]] = mem_wdata;
        else        mem_rdata = mem_m[mem_addr[11:4]];
      end
      if (ls_req && !hold && ($urandom % 3 != 0)) begin
        ls_gnt = 1'b1;
        ls_served++;
        if (ls_we) ls_m[ls_addr[11:4]] = ls_wdata;
        else       ls_rdata = ls_m[ls_addr[11:4]];
      end
    end
  end

  task automatic enqueue(input int la, input int ma, input int len, input bit dir,
                         input int tag, output bit ack, output bit full, output bit bad);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_laddr = LA_W'(la);
    cmd_maddr = MA_W'(ma);
    cmd_len   = LEN_W'(len);
    cmd_dir   = dir;
    cmd_tag   = TAG_W'(tag);
    #1;
    ack = cmd_ack; full = cmd_full; bad = cmd_bad;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic model(input int la, input int ma, input int len, input bit dir);
    for (int b = 0; b < len / 16; b++) begin
      int li = ((la >> 4) + b) & 255;
      int mi = ((ma >> 4) + b) & 255;
      if (!dir) ls_e[li] = mem_e[mi];
      else      mem_e[mi] = ls_e[li];
    end
  endtask

  task automatic wait_tag(input int tag, input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cmpl_status[tag]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic clear_tags(input logic [NT-1:0] m);
    @(negedge clk); cmpl_clr = m;
    @(negedge clk); cmpl_clr = '0;
  endtask

  task automatic compare_all(input string req);
    int em = 0, el = 0;
    for (int i = 0; i < 256; i++) begin
      if (mem_m[i] !== mem_e[i]) em++;
      if (ls_m[i] !== ls_e[i]) el++;
    end
    check(em == 0, req, "main memory words differing", em, 0);
    check(el == 0, req, "local store words differing", el, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit a, f, b, ok;
    int s0, l0, seed;
    seed = $urandom(32'h5eed_1234);
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = {$urandom, $urandom, $urandom, $urandom};
      ls_m[i]  = {$urandom, $urandom, $urandom, $urandom};
      mem_e[i] = mem_m[i];
      ls_e[i]  = ls_m[i];
    end
    repeat (3) @(posedge clk);
    #1;
    check(!mem_req && !ls_req && cmpl_status == '0, "R9", "reset idle",
          {mem_req, ls_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R4 directed get, 4 beats
    s0 = mem_served;
    enqueue(32'h100, 32'h2000, 64, 1'b0, 1, a, f, b);
    check(a && !f && !b, "R1", "get accepted", {a, f, b}, 3'b100);
    model(32'h100, 32'h2000, 64, 1'b0);
    wait_tag(1, 200, ok);
    check(ok, "R7", "tag1 complete", ok, 1);
    compare_all("R4");
    check(addr_log[s0] == 32'h2000 && addr_log[s0+1] == 32'h2010 &&
          addr_log[s0+2] == 32'h2020 && addr_log[s0+3] == 32'h2030 &&
          mem_served - s0 == 4, "R6", "ascending beat addresses",
          addr_log[s0+3], 32'h2030);

    // R5 directed put, 3 beats
    s0 = mem_served;
    enqueue(32'h300, 32'h2800, 48, 1'b1, 2, a, f, b);
    model(32'h300, 32'h2800, 48, 1'b1);
    wait_tag(2, 200, ok);
    check(ok, "R7", "tag2 complete", ok, 1);
    compare_all("R5");
    check(addr_log[s0+2] == 32'h2820, "R6", "put third beat address",
          addr_log[s0+2], 32'h2820);

    // R8 zero length
    s0 = mem_served; l0 = ls_served;
    enqueue(32'h40, 32'h50, 0, 1'b0, 3, a, f, b);
    check(a, "R8", "zero length accepted", a, 1);
    wait_tag(3, 20, ok);
    check(ok && mem_served == s0 && ls_served == l0, "R8", "zero length no traffic",
          mem_served - s0 + ls_served - l0, 0);

    // R3 malformed commands
    enqueue(0, 0, 16400, 1'b0, 4, a, f, b);
    check(!a && b && !f, "R3", "oversize rejected", {a, f, b}, 3'b001);
    enqueue(0, 0, 24, 1'b0, 4, a, f, b);
    check(!a && b, "R3", "misaligned length rejected", {a, f, b}, 3'b001);
    enqueue(8, 0, 32, 1'b0, 4, a, f, b);
    check(!a && b, "R3", "misaligned local address rejected", {a, f, b}, 3'b001);
    enqueue(0, 4, 32, 1'b1, 4, a, f, b);
    check(!a && b, "R3", "misaligned main address rejected", {a, f, b}, 3'b001);
    repeat (5) @(negedge clk);
    check(!cmpl_status[4] && !mem_req && !ls_req, "R3", "rejected not executed",
          cmpl_status[4], 0);

    // R7 clear
    clear_tags(NT'(1) << 1);
    #1;
    check(cmpl_status[1] == 1'b0 && cmpl_status[2] && cmpl_status[3], "R7",
          "clear only bit 1", cmpl_status[3:0], 4'b1100);
    clear_tags('1);

    // R2 fill sixteen while stalled
    hold = 1'b1;
    for (int i = 0; i < 16; i++) begin
      enqueue(32'h800 + 16*i, 32'h3000 + 16*i, 16, 1'b0, 8 + i, a, f, b);
      model(32'h800 + 16*i, 32'h3000 + 16*i, 16, 1'b0);
      if (!a) check(0, "R1", "fill accept", i, 16);
    end
    check(1, "R1", "sixteen accepted", 16, 16);
    enqueue(0, 32'h3800, 16, 1'b0, 30, a, f, b);
    check(!a && f && !b, "R2", "seventeenth refused full", {a, f, b}, 3'b010);
    enqueue(0, 0, 24, 1'b0, 30, a, f, b);
    check(!a && f && !b, "R3", "full wins over malformed", {a, f, b}, 3'b010);
    s0 = mem_served;
    hold = 1'b0;
    wait_tag(23, 2000, ok);
    check(ok && cmpl_status[23:8] == 16'hffff && !cmpl_status[30], "R2",
          "all sixteen done, refused one absent", cmpl_status[31:8], 24'h00ffff);
    check(addr_log[s0] == 32'h3000 && addr_log[s0+1] == 32'h3010 &&
          addr_log[s0+15] == 32'h30f0, "R6", "commands start in order",
          addr_log[s0+1], 32'h3010);
    compare_all("R4");
    clear_tags('1);

    // R3 maximum legal length
    s0 = mem_served;
    enqueue(0, 32'h10000, 16384, 1'b0, 5, a, f, b);
    check(a, "R3", "16384 bytes accepted", {a, f, b}, 3'b100);
    model(0, 32'h10000, 16384, 1'b0);
    wait_tag(5, 40000, ok);
    check(ok && mem_served - s0 == 1024, "R6", "max length beat count",
          mem_served - s0, 1024);
    compare_all("R4");
    clear_tags('1);

    // random batches, mixed direction, overlapping regions
    for (int bt = 0; bt < 6; bt++) begin
      int n = 4 + ($urandom % 12);
      for (int i = 0; i < n; i++) begin
        int la = ($urandom % 256) << 4;
        int ma = ($urandom % 256) << 4;
        int ln = ($urandom % 9) << 4;
        bit dr = 1'(($urandom % 2));
        enqueue(la, ma, ln, dr, i, a, f, b);
        if (!a) check(0, "R1", "random accept", {a, f, b}, 3'b100);
        model(la, ma, ln, dr);
      end
      wait_tag(n - 1, 3000, ok);
      check(ok && cmpl_status == NT'((64'd1 << n) - 1), "R7",
            "random batch tags", cmpl_status, (64'd1 << n) - 1);
      compare_all(dr_name(bt));
      clear_tags('1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic string dr_name(input int bt);
    return (bt % 2 == 0) ? "R4" : "R5";
  endfunction
endmodule